// File: doc/BRIEF.md
# Overlapped Convert-and-Multiply Compensator Sequencer

This block runs a sampled compensator as a two-stage pipeline. The first stage is input conversion and the second is a single-level multiply stage. A periodic sample tick starts a new conversion on an external converter. The block captures the returned word and hands it to a multiply stage at the following tick. At the tick after that, the weighted sum is loaded into a registered control output. Conversion of sample k+1 runs during the multiply for sample k. Both stages are therefore busy in every tick interval, and the sample rate is one sample per stage time instead of one per two stage times.

The multiply stage forms all products of the coefficients and the recent samples at once, with no product waiting on another, and sums them. The pipeline therefore adds exactly one tick of series delay to the designed compensator. The designer absorbs that delay by modelling it as part of the plant. A converter that has not answered by the next tick raises a sticky overrun flag, and the previous sample is reused so that the tick cadence never slips.

Top module: `comp_seq`

## Requirements
- R1: `adc_start` is high for exactly the one clock cycle that follows each clock edge at which `tick` is sampled high, and low at all other times.
- R2: While a conversion is outstanding, the first `adc_done` pulse that arrives strictly before the next tick edge stores `adc_data`. A `adc_done` pulse at any other time is ignored and changes no later output.
- R3: At each tick edge after the first, the stored sample (or the reused one) enters the multiply stage. The first tick after reset starts no multiply.
- R4: If no `adc_done` is taken before the next tick, including a `adc_done` that lands on that tick edge, `overrun` is set from that tick edge on and stays set until reset. The sample value last stored is then used again for that slot.
- R5: The result for a sample slot is the signed sum over taps i of c_i times x(k-i). Coefficient c_i sits at `coef[i*CW +: CW]`, tap 0 weights the newest sample x(k), and samples that are older than the first conversion count as zero.
- R6: `mul_busy` is high for exactly `MUL_CYC` cycles, starting in the cycle right after a tick edge that starts a multiply. Tick edges must be more than `MUL_CYC` cycles apart.
- R7: The sample from the conversion started at tick n appears on `ctl_out` with `ctl_valid` high for one cycle right after tick edge n+2. `ctl_out` holds its value in every cycle in which `ctl_valid` is low, and no valid appears for the first two ticks after reset.
- R8: During reset, `adc_start`, `ctl_valid`, `ctl_out`, `mul_busy` and `overrun` are all zero.
- R9: In the cycle after every tick edge except the first, `adc_start` and `mul_busy` are both high: the next conversion and the current multiply overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample tick, one cycle wide |
| coef | input | NTAP*CW | Packed signed coefficients, tap i at bits i*CW |
| adc_start | output | 1 | Conversion start pulse |
| adc_done | input | 1 | Conversion finished pulse |
| adc_data | input | DW | Signed converted sample, valid with adc_done |
| ctl_out | output | DW+CW+clog2(NTAP) | Registered signed control value |
| ctl_valid | output | 1 | One-cycle marker of a new ctl_out value |
| mul_busy | output | 1 | Multiply stage is running |
| overrun | output | 1 | Sticky late-conversion flag |

## Verification
A wrong converter-stage state shows up in the tick slot where it occurs. Either `overrun` rises at a tick when it should not, or a wrong or stale sample enters the history and corrupts `ctl_out` exactly two ticks later. The bad sample keeps affecting the output for NTAP slots. A wrong multiply-stage state shows at once on `mul_busy` in the same interval, or as a missing or misplaced `ctl_valid` at the next tick. Every tick slot is compared against an arithmetic model for converter latencies from one cycle up to the late boundary, and also with stray done pulses and mixed late conversions.

// File: rtl/comp_seq_pkg.sv
package comp_seq_pkg;

    typedef enum logic [1:0] {
        CV_IDLE = 2'd0,
        CV_WAIT = 2'd1,
        CV_HELD = 2'd2
    } cv_state_t;

    typedef enum logic [1:0] {
        MU_IDLE = 2'd0,
        MU_RUN  = 2'd1,
        MU_DONE = 2'd2
    } mu_state_t;

endpackage

// File: rtl/comp_seq_conv.sv
module comp_seq_conv
    import comp_seq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          cv_done,
    input  logic [DW-1:0] cv_data,
    output logic          cv_start,
    output logic          hand_ok,
    output logic [DW-1:0] hand_data,
    output logic          overrun
);

    cv_state_t    state_q, state_d;
    logic [DW-1:0] cap_q;

    // next-state: a tick always launches a fresh conversion
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CV_IDLE: if (tick) state_d = CV_WAIT;
            CV_WAIT: begin
                if (tick)         state_d = CV_WAIT;
                else if (cv_done) state_d = CV_HELD;
            end
            CV_HELD: if (tick) state_d = CV_WAIT;
            default: state_d = CV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CV_IDLE;
        else        state_q <= state_d;
    end

    // outputs and captured data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cv_start <= 1'b0;
            cap_q    <= '0;
            overrun  <= 1'b0;
        end else begin
            cv_start <= tick;
            if (state_q == CV_WAIT && !tick && cv_done)
                cap_q <= cv_data;
            if (state_q == CV_WAIT && tick)
                overrun <= 1'b1;
        end
    end

    assign hand_ok   = (state_q != CV_IDLE);
    assign hand_data = cap_q;

endmodule

// File: rtl/comp_seq_mul.sv
module comp_seq_mul
    import comp_seq_pkg::*;
#(
    parameter int DW      = 8,
    parameter int CW      = 8,
    parameter int NTAP    = 3,
    parameter int MUL_CYC = 4,
    parameter int OW      = DW + CW + $clog2(NTAP)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go,
    input  logic [DW-1:0]        x_in,
    input  logic [NTAP*CW-1:0]   coef,
    output logic                 busy,
    output logic                 res_ready,
    output logic [OW-1:0]        res
);

    localparam int PW   = DW + CW;
    localparam int CNTW = $clog2(MUL_CYC + 1);
    localparam logic [CNTW-1:0] LAST = CNTW'(MUL_CYC - 1);

    mu_state_t            state_q, state_d;
    logic [CNTW-1:0]      cnt_q;
    logic [DW-1:0]        hist [NTAP];
    logic signed [PW-1:0] prod [NTAP];
    logic signed [OW-1:0] acc;
    logic [OW-1:0]        res_q;

    // sample history: shifts once per started multiply
    for (genvar g = 0; g < NTAP; g++) begin : g_hist
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n)  hist[0] <= '0;
                else if (go) hist[0] <= x_in;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (!rst_n)  hist[g] <= '0;
                else if (go) hist[g] <= hist[g-1];
            end
        end
        // every product depends only on registered values: one level
        assign prod[g] = PW'($signed(hist[g])) * PW'($signed(coef[g*CW +: CW]));
    end

    always_comb begin
        acc = '0;
        for (int i = 0; i < NTAP; i++)
            acc = acc + OW'(prod[i]);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MU_IDLE: if (go) state_d = MU_RUN;
            MU_RUN: begin
                if (go)                 state_d = MU_RUN;
                else if (cnt_q == LAST) state_d = MU_DONE;
            end
            MU_DONE: if (go) state_d = MU_RUN;
            default: state_d = MU_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MU_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            res_q <= '0;
        end else if (go) begin
            cnt_q <= '0;
        end else if (state_q == MU_RUN) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST)
                res_q <= acc;
        end
    end

    assign busy      = (state_q == MU_RUN);
    assign res_ready = (state_q == MU_DONE);
    assign res       = res_q;

endmodule

// File: rtl/comp_seq_out.sv
module comp_seq_out #(
    parameter int OW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          res_ready,
    input  logic [OW-1:0] res,
    output logic [OW-1:0] ctl_out,
    output logic          ctl_valid
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_out   <= '0;
            ctl_valid <= 1'b0;
        end else if (tick && res_ready) begin
            ctl_out   <= res;
            ctl_valid <= 1'b1;
        end else begin
            ctl_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/comp_seq.sv
module comp_seq #(
    parameter  int DW      = 8,
    parameter  int CW      = 8,
    parameter  int NTAP    = 3,
    parameter  int MUL_CYC = 4,
    localparam int OW      = DW + CW + $clog2(NTAP)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [NTAP*CW-1:0] coef,
    output logic               adc_start,
    input  logic               adc_done,
    input  logic [DW-1:0]      adc_data,
    output logic [OW-1:0]      ctl_out,
    output logic               ctl_valid,
    output logic               mul_busy,
    output logic               overrun
);

    logic          hand_ok;
    logic [DW-1:0] hand_data;
    logic          res_ready;
    logic [OW-1:0] res;

    comp_seq_conv #(.DW(DW)) u_conv (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cv_done   (adc_done),
        .cv_data   (adc_data),
        .cv_start  (adc_start),
        .hand_ok   (hand_ok),
        .hand_data (hand_data),
        .overrun   (overrun)
    );

    comp_seq_mul #(
        .DW(DW), .CW(CW), .NTAP(NTAP), .MUL_CYC(MUL_CYC), .OW(OW)
    ) u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (tick && hand_ok),
        .x_in      (hand_data),
        .coef      (coef),
        .busy      (mul_busy),
        .res_ready (res_ready),
        .res       (res)
    );

    comp_seq_out #(.OW(OW)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .res_ready (res_ready),
        .res       (res),
        .ctl_out   (ctl_out),
        .ctl_valid (ctl_valid)
    );

endmodule

// File: rtl/comp_seq_chk.sv
module comp_seq_chk #(
    parameter int OW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          adc_start,
    input logic          ctl_valid,
    input logic [OW-1:0] ctl_out,
    input logic          overrun,
    input logic          mul_busy,
    input logic          res_ready
);

    a_r1_start_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> adc_start);

    a_r1_no_spurious_start: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !adc_start);

    a_r4_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    a_r6_mul_ends_before_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> !mul_busy);

    a_r7_valid_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_valid |-> $past(tick));

    a_r3_valid_needs_result: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_valid |-> $past(res_ready));

    a_r7_out_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_valid |-> $stable(ctl_out));

endmodule

bind comp_seq comp_seq_chk #(.OW(OW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .adc_start (adc_start),
    .ctl_valid (ctl_valid),
    .ctl_out   (ctl_out),
    .overrun   (overrun),
    .mul_busy  (mul_busy),
    .res_ready (res_ready)
);

// File: tb/sim_comp_seq.sv
module sim_comp_seq;

    localparam int DW = 8, CW = 8, NT = 3, MC = 4, OW = 18;
    localparam int P = 10, NTICK = 12, NRUN = 10;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic               rst_n = 1'b0;
    logic               tick = 1'b0;
    logic [NT*CW-1:0]   coef = '0;
    logic               adc_start;
    logic               adc_done = 1'b0;
    logic [DW-1:0]      adc_data = '0;
    logic [OW-1:0]      ctl_out;
    logic               ctl_valid;
    logic               mul_busy;
    logic               overrun;

    int checks = 0;
    int errors = 0;

    comp_seq #(.DW(DW), .CW(CW), .NTAP(NT), .MUL_CYC(MC)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .coef(coef),
        .adc_start(adc_start), .adc_done(adc_done), .adc_data(adc_data),
        .ctl_out(ctl_out), .ctl_valid(ctl_valid),
        .mul_busy(mul_busy), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int lat_of(input int r, input int n);
        if (r < 9) return r + 1;
        return (n % 3 == 1) ? 15 : 2 + (n % 5);
    endfunction

    function automatic int samp(input int r, input int n);
        return ((n * 37 + r * 11 + 5) % 256) - 128;
    endfunction

    function automatic int coefv(input int r, input int i);
        return ((r * 7 + i * 13) % 31) - 15;
    endfunction

    task automatic run(input int r);
        int xs [NTICK];
        int prev, cd, cidx, e, j, m, expv, lat;
        bit stray_en, stray_pend, late_seen, exp_ovr;
        for (int i = 0; i < NT; i++) coef[i*CW +: CW] = CW'(coefv(r, i));
        rst_n = 1'b0; tick = 1'b0; adc_done = 1'b0; adc_data = '0;
        repeat (2) @(negedge clk);
        // R8 reset state
        chk(adc_start == 0 && ctl_valid == 0 && mul_busy == 0 && overrun == 0,
            "R8 control bits in reset", int'(adc_start) + int'(ctl_valid) + int'(mul_busy) + int'(overrun), 0);
        chk(ctl_out == '0, "R8 ctl_out in reset", int'(ctl_out), 0);
        rst_n = 1'b1;
        prev = 0;
        for (int n = 0; n < NTICK; n++) begin
            xs[n] = (lat_of(r, n) <= P - 2) ? samp(r, n) : prev;
            prev  = xs[n];
        end
        cd = 0; cidx = 0; stray_pend = 1'b0;
        stray_en = (r < 9) && (r % 2 == 0) && (lat_of(r, 0) <= P - 3);
        for (int cyc = 0; cyc < NTICK * P + 1; cyc++) begin
            if (cyc > 0) begin
                e = cyc - 1; j = e % P; m = e / P;
                chk(adc_start == (j == 0), "R1 start pulse", int'(adc_start), int'(j == 0));
                chk(ctl_valid == (j == 0 && m >= 2), "R7 valid timing", int'(ctl_valid), int'(j == 0 && m >= 2));
                if (j == 0 && m >= 2) begin
                    expv = 0;
                    for (int i = 0; i < NT; i++)
                        if (m - 2 - i >= 0) expv += coefv(r, i) * xs[m - 2 - i];
                    chk(int'($signed(ctl_out)) == expv, "R5 R7 R2 R3 output value", int'($signed(ctl_out)), expv);
                end
                chk(mul_busy == (m >= 1 && j < MC), "R6 busy window", int'(mul_busy), int'(m >= 1 && j < MC));
                if (j == 0 && m >= 1)
                    chk(adc_start && mul_busy, "R9 overlap", int'(adc_start && mul_busy), 1);
                if (j == 0) begin
                    late_seen = 1'b0;
                    for (int n = 0; n < m; n++)
                        if (lat_of(r, n) > P - 2) late_seen = 1'b1;
                    exp_ovr = late_seen;
                    chk(overrun == exp_ovr, "R4 overrun flag", int'(overrun), int'(exp_ovr));
                end
            end
            // converter model
            adc_done = 1'b0;
            if (stray_pend) begin
                adc_done = 1'b1; adc_data = 8'h5A; stray_pend = 1'b0;
            end
            if (cd > 0) begin
                cd--;
                if (cd == 0) begin
                    adc_done = 1'b1;
                    adc_data = DW'(samp(r, cidx));
                    stray_pend = stray_en;
                end
            end
            if (cyc > 0 && adc_start) begin
                lat  = lat_of(r, (cyc - 1) / P);
                cd   = lat;
                cidx = (cyc - 1) / P;
            end
            tick = (cyc % P == 0) && (cyc / P < NTICK);
            @(negedge clk);
        end
        tick = 1'b0;
    endtask

    initial begin
        for (int r = 0; r < NRUN; r++) run(r);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule